// File: doc/BRIEF.md
# Quarter-Wave Sine Table Mapper

This block gives a full sine period of 48000 phase steps, each step being 2π/48000, while storing only one quarter of the wave. The stored quarter is a 12000-word, 16-bit table that sits behind a shared arbiter. A phase index from 0 to 47999 enters on a valid/ready stream. The block sorts the phase into one of four quadrants by comparing it with multiples of 12000. Decoding the top bits would not work here, because 48000 is not a power of two.

From the quadrant the block forms a table address, either direct or mirrored, and a sign. It holds a request on the arbiter port until the data-valid pulse arrives. It then returns the signed sample, negated when the phase lies in the second half of the period, on an output valid/ready stream.

Back-pressure rules:
- An input phase is taken only when the fetch path is idle and the output register is empty or is being drained in that same cycle.
- A presented output holds its value until `out_ready` is high.
- The stored amplitude stays slightly below full scale, so negation never saturates.

Top module: `sinmap_quarter_lut`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `rom_req` is 0.
- R2: A phase p in 0..11999 reads table address p, and the sample is returned unchanged.
- R3: A phase p in 12000..23999 reads table address 23999−p, and the sample is returned unchanged.
- R4: A phase p in 24000..35999 reads table address p−24000, and the sample is returned two's-complement negated.
- R5: A phase p in 36000..47999 reads table address 47999−p, and the sample is returned two's-complement negated.
- R6: `rom_req` stays high with a stable `rom_addr` until `rom_valid` is seen. It is low in the cycle after the `rom_valid` pulse. `rom_data` is used only in the cycle in which `rom_valid` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` does not change.
- R8: Each accepted phase yields exactly one output sample, in acceptance order. A new phase may be accepted in the same cycle in which the held output is taken.
- R9: `out_valid` rises in the cycle after `rom_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Phase offered |
| in_ready | output | 1 | Phase can be taken this cycle |
| in_phase | input | 16 | Phase index, 0..47999 |
| out_valid | output | 1 | Sample held on `out_sample` |
| out_ready | input | 1 | Consumer takes the sample |
| out_sample | output | 16 | Signed sine sample |
| rom_req | output | 1 | Table read request, held until granted |
| rom_addr | output | 14 | Table address, 0..11999 |
| rom_valid | input | 1 | One-cycle grant pulse with data |
| rom_data | input | 16 | Table word, meaningful only with `rom_valid` |

## Verification
Two functions can fall in the same cycle: draining the held output and accepting the next phase. The bench provokes this by keeping `in_valid` high through a sweep of all 48000 phases while `out_ready` is mostly high. A cycle-accurate queue model then checks that each popped sample belongs to the phase pushed before it, and that the newly accepted phase drives the next request address. Occasional `out_ready` stalls and delayed grants make the same handoff also happen after waits. In those cases the held sample must stay frozen, and the request must stay up until granted.

// File: rtl/sinmap_pkg.sv
package sinmap_pkg;
  typedef enum logic [1:0] {
    QD_RISE  = 2'd0,
    QD_FALL  = 2'd1,
    QD_DIP   = 2'd2,
    QD_CLIMB = 2'd3
  } quad_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_REQ  = 1'b1
  } fetch_st_e;
endpackage

// File: rtl/sinmap_fold.sv
module sinmap_fold
  import sinmap_pkg::*;
#(
  parameter int PW      = 16,
  parameter int QUARTER = 12000,
  parameter int AW      = 14
) (
  input  logic [PW-1:0] phase,
  output logic [AW-1:0] addr,
  output quad_e         quad
);
  localparam logic [PW:0] B1 = (PW+1)'(QUARTER);
  localparam logic [PW:0] B2 = (PW+1)'(2*QUARTER);
  localparam logic [PW:0] B3 = (PW+1)'(3*QUARTER);
  localparam logic [PW:0] M2 = (PW+1)'(2*QUARTER - 1);
  localparam logic [PW:0] M4 = (PW+1)'(4*QUARTER - 1);

  logic [PW:0] ext;
  assign ext = {1'b0, phase};

  always_comb begin
    if (ext < B1) begin
      quad = QD_RISE;
      addr = AW'(ext);
    end else if (ext < B2) begin
      quad = QD_FALL;
      addr = AW'(M2 - ext);
    end else if (ext < B3) begin
      quad = QD_DIP;
      addr = AW'(ext - B2);
    end else begin
      quad = QD_CLIMB;
      addr = AW'(M4 - ext);
    end
  end

  // R2 R3 R4 R5: every legal phase folds into the stored quarter
  always_comb begin
    if (!$isunknown(phase) && ({1'b0, phase} <= M4))
      a_r2_fold_range: assert ({1'b0, addr} < (AW+1)'(QUARTER));
  end
endmodule

// File: rtl/sinmap_fetch.sv
module sinmap_fetch
  import sinmap_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  quad_e         quad_in,
  output logic          busy,
  output logic          rom_req,
  output logic [AW-1:0] rom_addr,
  input  logic          rom_valid,
  input  logic [DW-1:0] rom_data,
  output logic          cap,
  output logic [DW-1:0] cap_data,
  output logic          cap_neg
);
  fetch_st_e     st;
  logic [AW-1:0] addr_q;
  quad_e         quad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= FS_IDLE;
      addr_q <= '0;
      quad_q <= QD_RISE;
    end else begin
      case (st)
        FS_IDLE: if (start) begin
          addr_q <= addr_in;
          quad_q <= quad_in;
          st     <= FS_REQ;
        end
        FS_REQ: if (rom_valid) st <= FS_IDLE;
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign busy     = (st != FS_IDLE);
  assign rom_req  = (st == FS_REQ);
  assign rom_addr = addr_q;
  assign cap      = (st == FS_REQ) && rom_valid;
  assign cap_data = rom_data;
  assign cap_neg  = (quad_q == QD_DIP) || (quad_q == QD_CLIMB);

  // R6: request held with stable address until granted
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && !rom_valid) |=> (rom_req && $stable(rom_addr)));
  // R6: request dropped after the grant pulse
  a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && rom_valid) |=> !rom_req);
endmodule

// File: rtl/sinmap_out.sv
module sinmap_out #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap,
  input  logic [DW-1:0]        cap_data,
  input  logic                 cap_neg,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  logic signed [DW-1:0] word;
  assign word = $signed(cap_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (cap) begin
      out_valid  <= 1'b1;
      out_sample <= cap_neg ? -word : word;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R7: a held sample survives back-pressure unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));
  // R9: capture appears on the output the following cycle
  a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> out_valid);
endmodule

// File: rtl/sinmap_quarter_lut.sv
module sinmap_quarter_lut
  import sinmap_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int QUARTER = 12000,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = $clog2(QUARTER)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PHASE_W-1:0]       in_phase,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_sample,
  output logic                     rom_req,
  output logic [ADDR_W-1:0]        rom_addr,
  input  logic                     rom_valid,
  input  logic [DATA_W-1:0]        rom_data
);
  logic [ADDR_W-1:0] f_addr;
  quad_e             f_quad;
  logic              busy, start, cap, cap_neg;
  logic [DATA_W-1:0] cap_data;

  sinmap_fold #(.PW(PHASE_W), .QUARTER(QUARTER), .AW(ADDR_W)) u_fold (
    .phase(in_phase), .addr(f_addr), .quad(f_quad)
  );

  assign in_ready = !busy && (!out_valid || out_ready);
  assign start    = in_valid && in_ready;

  sinmap_fetch #(.AW(ADDR_W), .DW(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start),
    .addr_in(f_addr), .quad_in(f_quad), .busy(busy),
    .rom_req(rom_req), .rom_addr(rom_addr),
    .rom_valid(rom_valid), .rom_data(rom_data),
    .cap(cap), .cap_data(cap_data), .cap_neg(cap_neg)
  );

  sinmap_out #(.DW(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_data(cap_data),
    .cap_neg(cap_neg), .out_ready(out_ready),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  // R8: an accepted phase always launches a table request next cycle
  a_r8_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> rom_req);
endmodule

// File: tb/sinmap_quarter_lut_test.sv
module sinmap_quarter_lut_test;
  localparam real TAU = 6.283185307179586;
  localparam int  AMP = 32000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [15:0] in_phase = '0;
  logic in_ready, out_valid, rom_req, rom_valid;
  logic signed [15:0] out_sample;
  logic [13:0] rom_addr;
  logic [15:0] rom_data;

  int tests = 0, fails = 0, cyc = 0, gwait = 0, outs = 0;
  bit done = 0;
  int pend[$];
  int last_phase = 0;
  logic prev_req = 0, prev_rv = 0, prev_hold = 0;
  logic signed [15:0] prev_smp = '0;

  always #10 clk = ~clk;

  sinmap_quarter_lut uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .rom_req(rom_req), .rom_addr(rom_addr),
    .rom_valid(rom_valid), .rom_data(rom_data)
  );

  function automatic int rom_val(int a);
    return int'(real'(AMP) * $sin(TAU * (real'(a) + 0.5) / 48000.0));
  endfunction
  function automatic int ref_val(int p);
    return int'(real'(AMP) * $sin(TAU * (real'(p) + 0.5) / 48000.0));
  endfunction
  function automatic int exp_addr(int p);
    if (p < 12000) return p;
    if (p < 24000) return 23999 - p;
    if (p < 36000) return p - 24000;
    return 47999 - p;
  endfunction
  function automatic string qtag(int p);
    if (p < 12000) return "R2";
    if (p < 24000) return "R3";
    if (p < 36000) return "R4";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // behavioural quarter table: one-cycle latency, occasional grant delay
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      rom_valid <= 0; rom_data <= 16'hDEAD;
    end else if (rom_req && !rom_valid) begin
      if (gwait > 0) gwait <= gwait - 1;
      else begin
        rom_valid <= 1; rom_data <= 16'(rom_val(int'(rom_addr)));
      end
    end else begin
      rom_valid <= 0; rom_data <= 16'hDEAD;
      gwait <= (int'(rom_addr) % 31 == 0) ? 2 : 0;
    end
  end

  // consumer with short periodic stalls
  always @(posedge clk) #2 out_ready <= rst_n && ((cyc % 64) >= 2);

  // per-cycle reference monitor
  always @(negedge clk) if (rst_n) begin
    if (prev_hold) begin
      check(out_valid === 1'b1, "R7 valid held", int'(out_valid), 1);
      check(out_sample === prev_smp, "R7 sample held", int'(out_sample), int'(prev_smp));
    end
    if (prev_rv) begin
      check(rom_req === 1'b0, "R6 req drop", int'(rom_req), 0);
      check(out_valid === 1'b1, "R9 out after grant", int'(out_valid), 1);
    end
    if (rom_req && !prev_req)
      check(int'(rom_addr) == exp_addr(last_phase), {qtag(last_phase), " addr"},
            int'(rom_addr), exp_addr(last_phase));
    if (out_valid && out_ready) begin
      if (pend.size() == 0) check(0, "R8 spurious output", 1, 0);
      else begin
        int p, e, d;
        p = pend.pop_front();
        e = ref_val(p);
        d = int'(out_sample) - e;
        check(d >= -1 && d <= 1, {qtag(p), " sample"}, int'(out_sample), e);
        outs++;
      end
    end
    if (in_valid && in_ready) begin
      pend.push_back(int'(in_phase));
      last_phase = int'(in_phase);
    end
    prev_req  = rom_req;
    prev_rv   = rom_valid;
    prev_hold = out_valid && !out_ready;
    prev_smp  = out_sample;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(rom_req === 1'b0, "R1 rom_req", int'(rom_req), 0);
    @(posedge clk); #2 rst_n = 1;
    for (int p = 0; p < 48000; p++) begin
      in_valid = 1; in_phase = 16'(p);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #2;
    end
    in_valid = 0;
    for (int w = 0; w < 200 && pend.size() != 0; w++) @(negedge clk);
    check(pend.size() == 0, "R8 queue drained", pend.size(), 0);
    check(outs == 48000, "R8 output count", outs, 48000);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", outs, 48000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule